// File: doc/BRIEF.md
# Reloading Prescaled Down-Counter Channel

This block is a single timer channel. A 32-bit counter counts down once per prescaler strobe. The strobe comes from a free-running divider, and a three-bit field in the control word picks the divide ratio. When the counter is already at zero and another strobe arrives, the counter takes the value of a separate reload register on the next edge. At the same time a sticky underflow flag is set. That flag drives the interrupt output, gated by an enable bit.

Software reaches the channel through a word-indexed register port with a combinational read path. Index 0 holds the reload value, index 1 the live count and index 2 the control word. Index 3 is an unimplemented slot. An external run-enable input, normally driven from a shared start register, gates counting. When it is low the count is held, and when it returns high counting resumes from the held value.

Top module: `reload_timer_channel`

## Requirements
- R1: After reset the reload register and the counter read 0xFFFFFFFF, the control word reads 0 and `irq` is low.
- R2: Control bits 2:0 select the prescale ratio: values 0 to 4 divide by 4, 16, 64, 256 and 1024. Any write to index 2 restarts the divider from zero. The first decrement then lands on the ratio-th clock edge after that write, and further decrements follow at that interval.
- R3: Prescale values 5, 6 and 7 produce no strobe, so the counter does not change.
- R4: A strobe that finds the counter at 0 loads the reload value into the counter and sets the underflow flag, which reads back in control bit 8.
- R5: While `run_en` is low the counter holds and no underflow happens. After `run_en` returns high, counting resumes from the held value.
- R6: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: Writing control bit 8 as 0 clears the underflow flag, and writing it as 1 leaves the flag as it was. If a clear and a new underflow fall in the same cycle, the flag stays set.
- R8: Writes to control bits 15:9 are dropped and those bits read 0. Control bits 7:0 read back as written. Index 3 reads 0, and a write to it has no effect.
- R9: A write to index 0 changes only the reload value. A write to index 1 loads the counter directly. When that write lands in the same cycle as an underflow, it wins: no reload happens and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Word index of the register accessed |
| reg_we | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| run_en | input | 1 | Run enable from the external start register |
| irq | output | 1 | Underflow interrupt request |

## Verification
The embedded assertions check, on every cycle, the local cause-and-effect rules:
- the counter holds when it has neither a strobe nor a write;
- a direct write lands exactly;
- an underflow reloads the counter;
- the flag rises only after an underflow, and a write of 0 without a concurrent underflow clears it;
- strobes never come back to back.

Only the bench scenarios can show the absolute timing of each of the five prescale ratios measured from a control write. The same holds for reset contents, for resume after a pause, for readback masking of reserved bits and of the unused index, and for the write-beats-underflow priority seen at the ports.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DIV_W    = 10;
    localparam int CTRL_W   = 16;
    localparam int FLAG_BIT = 8;
    localparam int MAX_PSC  = 4;

    typedef enum logic [1:0] {
        IDX_RELOAD = 2'd0,
        IDX_COUNT  = 2'd1,
        IDX_CTRL   = 2'd2,
        IDX_SPARE  = 2'd3
    } reg_idx_e;

    // Stored part of the control word (bits 7:0)
    typedef struct packed {
        logic [1:0] cap_ctl;
        logic       irq_en;
        logic [1:0] edge_sel;
        logic [2:0] psc_sel;
    } ctrl_t;

    // Low-bit mask whose all-ones state marks a strobe; ratio 4^(sel+1)
    function automatic logic [DIV_W-1:0] psc_mask(input logic [2:0] sel);
        logic [DIV_W-1:0] m;
        m = '0;
        for (int i = 0; i <= MAX_PSC; i++) begin
            if (sel == i[2:0]) m = DIV_W'((1 << (2 * (i + 1))) - 1);
        end
        return m;
    endfunction

    function automatic logic psc_valid(input logic [2:0] sel);
        return sel <= 3'(MAX_PSC);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [2:0] psc_sel,
    output logic       strobe
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask   = psc_mask(psc_sel);
        strobe = psc_valid(psc_sel) && ((div_q & mask) == mask);
    end

    // R2
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R3
    reserved_psc_chk: assert property (@(posedge clk) disable iff (rst)
        (psc_sel > 3'(MAX_PSC)) |-> !strobe);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] RESET_VAL = '1;

    assign underflow = tick && (cnt == '0) && !cnt_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= RESET_VAL;
            reload <= RESET_VAL;
        end else begin
            if (rld_we) reload <= rld_wdata;
            if (cnt_we)         cnt <= cnt_wdata;
            else if (underflow) cnt <= reload;
            else if (tick)      cnt <= cnt - 1'b1;
        end
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(cnt));

    // R9
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt == $past(cnt_wdata)));

    // R4
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '0 && !cnt_we) |=> (cnt == $past(reload)));

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [8:0] wdata,
    input  logic       underflow,
    output ctrl_t      ctrl,
    output logic       flag,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            flag <= 1'b0;
        end else begin
            if (we) ctrl <= ctrl_t'(wdata[7:0]);
            if (underflow)                    flag <= 1'b1;
            else if (we && !wdata[FLAG_BIT]) flag <= 1'b0;
        end
    end

    assign irq = flag && ctrl.irq_en;

    // R4
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(underflow));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !wdata[FLAG_BIT] && !underflow) |=> !flag);

endmodule

// File: rtl/reload_timer_channel.sv
module reload_timer_channel
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              run_en,
    output logic              irq
);

    logic       we_rld, we_cnt, we_ctrl;
    logic       strobe, tick, underflow, flag;
    ctrl_t      ctrl;
    logic [CNT_W-1:0] cnt, reload;

    always_comb begin
        we_rld  = reg_we && (reg_addr == ADDR_W'(IDX_RELOAD));
        we_cnt  = reg_we && (reg_addr == ADDR_W'(IDX_COUNT));
        we_ctrl = reg_we && (reg_addr == ADDR_W'(IDX_CTRL));
        tick    = strobe && run_en;
    end

    rtc_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (we_ctrl),
        .psc_sel (ctrl.psc_sel),
        .strobe  (strobe)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_we    (we_cnt),
        .cnt_wdata (reg_wdata),
        .rld_we    (we_rld),
        .rld_wdata (reg_wdata),
        .cnt       (cnt),
        .reload    (reload),
        .underflow (underflow)
    );

    rtc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .we        (we_ctrl),
        .wdata     (reg_wdata[8:0]),
        .underflow (underflow),
        .ctrl      (ctrl),
        .flag      (flag),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(IDX_RELOAD): reg_rdata = reload;
            ADDR_W'(IDX_COUNT):  reg_rdata = cnt;
            ADDR_W'(IDX_CTRL): begin
                reg_rdata[7:0]      = ctrl;
                reg_rdata[FLAG_BIT] = flag;
            end
            default:             reg_rdata = '0;
        endcase
    end

    // R5
    paused_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !underflow);

endmodule

// File: tb/sim_reload_timer_channel.sv
`timescale 1ns/1ps
module sim_reload_timer_channel;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        run_en;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    reload_timer_channel u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .run_en    (run_en),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R1 count",  v, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R1 ctrl",   v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_ratios();
        logic [31:0] v;
        run_en = 1'b1;
        for (int s = 0; s <= 4; s++) begin
            int r = 4 << (2 * s);
            wr(2'd2, 32'(s));
            wr(2'd1, 32'd1000);
            step(3 * r - 2);
            rd(2'd1, v); check($sformatf("R2 sel%0d before third", s), v, 32'd998);
            step(1);
            rd(2'd1, v); check($sformatf("R2 sel%0d third", s), v, 32'd997);
        end
    endtask

    task automatic t_reserved_psc();
        logic [31:0] v;
        run_en = 1'b1;
        wr(2'd2, 32'd5);
        wr(2'd1, 32'd50);
        step(1100);
        rd(2'd1, v); check("R3 sel5 stalls", v, 32'd50);
        wr(2'd2, 32'd7);
        step(300);
        rd(2'd1, v); check("R3 sel7 stalls", v, 32'd50);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        run_en = 1'b1;
        wr(2'd2, 32'h020);
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd1);
        step(5);
        rd(2'd1, v); check("R4 at zero", v, 32'd0);
        check("R6 irq before wrap", 32'(irq), 32'h0);
        step(1);
        rd(2'd1, v); check("R4 reloaded", v, 32'd5);
        rd(2'd2, v); check("R4 flag read", v, 32'h120);
        check("R6 irq after wrap", 32'(irq), 32'h1);
        wr(2'd2, 32'h120);
        rd(2'd2, v); check("R7 write one keeps", v, 32'h120);
        check("R7 irq kept", 32'(irq), 32'h1);
        wr(2'd2, 32'h020);
        rd(2'd2, v); check("R7 write zero clears", v, 32'h020);
        check("R7 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        run_en = 1'b1;
        wr(2'd2, 32'h000);
        wr(2'd1, 32'd0);
        step(3);
        rd(2'd2, v); check("R6 flag without enable", v, 32'h100);
        check("R6 irq masked", 32'(irq), 32'h0);
        wr(2'd2, 32'h120);
        check("R6 irq unmasked", 32'(irq), 32'h1);
        wr(2'd2, 32'h020);
    endtask

    task automatic t_pause();
        logic [31:0] v;
        run_en = 1'b0;
        wr(2'd2, 32'h000);
        wr(2'd1, 32'd10);
        step(40);
        rd(2'd1, v); check("R5 held", v, 32'd10);
        wr(2'd1, 32'd0);
        step(40);
        rd(2'd1, v); check("R5 no wrap paused", v, 32'd0);
        rd(2'd2, v); check("R5 no flag paused", v, 32'h0);
        wr(2'd1, 32'd10);
        run_en = 1'b1;
        step(8);
        rd(2'd1, v); check("R5 resumed", v, 32'd8);
    endtask

    task automatic t_masking();
        logic [31:0] v, c0;
        run_en = 1'b0;
        wr(2'd2, 32'hFFFF_FEFF);
        rd(2'd2, v); check("R8 reserved bits", v, 32'h0000_00FF);
        rd(2'd1, c0);
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, v); check("R8 spare index", v, 32'h0);
        rd(2'd1, v); check("R8 spare write no effect", v, c0);
        rd(2'd2, v); check("R8 ctrl after spare write", v, 32'h0000_00FF);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        run_en = 1'b0;
        wr(2'd1, 32'd33);
        wr(2'd0, 32'h1234);
        rd(2'd0, v); check("R9 reload written", v, 32'h1234);
        rd(2'd1, v); check("R9 count untouched", v, 32'd33);
        run_en = 1'b1;
        wr(2'd2, 32'h000);
        wr(2'd1, 32'd0);
        step(2);
        wr(2'd1, 32'd77);
        rd(2'd1, v); check("R9 write beats reload", v, 32'd77);
        rd(2'd2, v); check("R9 no flag on collision", v, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; run_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratios();
        t_reserved_psc();
        t_underflow();
        t_gating();
        t_pause();
        t_masking();
        t_priority();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule